// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

This block collects up to 64 device interrupt lines into one shared pending vector and hands them out to four CPUs. Each CPU owns an enable mask. The block keeps that CPU's routed vector equal to the mask ANDed with the pending vector. A CPU's level interrupt output stays high while its routed vector has any bit set.

For every CPU the block also pulses a per-line "delivered" vector and a per-line "retracted" vector. These carry exactly the lines that entered or left that CPU's routed vector on the last update. A line whose routed state did not change makes no event, so a repeated assertion or a rewrite of the same mask is silent.

Software reaches the block through 64-bit register accesses. The register index is the byte offset shifted right by six, so the lower six offset bits are ignored. The response logic is a small state machine with three named states:

- `RSP_IDLE`: no response this cycle.
- `RSP_READ`: read data is valid.
- `RSP_FAULT`: an error pulse is shown.

On every clock edge the machine moves to `RSP_READ` after an accepted legal read, to `RSP_FAULT` after any illegal access, and to `RSP_IDLE` after a legal write or an idle cycle. This holds whichever state it is in.

Top module: `irqr_router`

## Requirements
- R1: After reset all masks, routed vectors and the pending vector read as zero, every `cpu_irq` bit is low, and no delivered, retracted, read-valid or error pulse is present.
- R2: Register index n (0..NUM_CPUS-1) is CPU n's mask (read/write). Index NUM_CPUS+n is CPU n's routed vector (read-only). Index 2*NUM_CPUS is the pending vector (read-only). A legal read returns the value held before that cycle's updates, one cycle later with `rsp_rvalid` high. The routed vector of CPU n always equals mask n AND pending.
- R3: A mask write delivers to that CPU every line that becomes set in its routed vector: the mask bit goes 0 to 1 while the pending bit is set.
- R4: A mask write retracts from that CPU every line that was set in its routed vector and is clear after the write.
- R5: A device assertion event (`dev_evt_assert`=1) sets the line's pending bit. It delivers the line to every CPU whose mask has that bit and whose routed vector did not already hold it. Asserting an already pending line produces no event.
- R6: A device deassertion event clears a set pending bit and retracts the line from every CPU whose routed vector held it. A deassertion of a line that is not pending changes nothing and produces no event.
- R7: `cpu_irq[n]` is high exactly while CPU n's routed vector is nonzero.
- R8: A write to a read-only index, or any access to an index above 2*NUM_CPUS, pulses `rsp_err` for one cycle one cycle later, returns no read data and changes no state.
- R9: An access whose `req_size` is not 3 (log2 of 8 bytes) is illegal. It pulses `rsp_err`, produces no read data and changes no state.
- R10: Offset bits 5..0 are ignored. An access at a nonzero low offset reaches the same register as one at offset zero.
- R11: Any write or device event takes effect on the clock edge that accepts it. Outputs and a read issued in the next cycle observe the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset; register index is bits ADDR_W-1..6 |
| req_size | input | 2 | log2 of access bytes; only 3 is legal |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_rvalid |
| rsp_rvalid | output | 1 | Read data valid (state RSP_READ) |
| rsp_err | output | 1 | Illegal access pulse (state RSP_FAULT) |
| dev_evt_valid | input | 1 | Device line event present |
| dev_evt_assert | input | 1 | 1 = line asserted, 0 = line deasserted |
| dev_evt_line | input | LINE_W | Device line number |
| cpu_irq | output | NUM_CPUS | Level interrupt per CPU |
| cpu_post | output | NUM_CPUS*NUM_LINES | Lines delivered per CPU (CPU n at bits n*NUM_LINES upward) |
| cpu_withdraw | output | NUM_CPUS*NUM_LINES | Lines retracted per CPU, same layout |

## Verification
The bench builds the block with its defaults: four CPUs, 64 lines, a 12-bit offset and 64-bit data. With these values the pending register sits at index 8, the routed vectors at 4 to 7, and indices 9 to 63 are unmapped, so every decode class is reachable. Random device events are drawn from a small line pool so that repeated assertions, deassertions of idle lines and mask overlaps occur often. Some cycles carry a mask write and a device event together, which exercises the combined update of both operands.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_READ  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    localparam logic [1:0] FULL_WORD_SIZE = 2'd3;
    localparam int unsigned IDX_SHIFT = 6;

endpackage

// File: rtl/irqr_regif.sv
module irqr_regif
    import irqr_pkg::*;
#(
    parameter int unsigned NUM_CPUS  = 4,
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned DATA_W    = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [IDX_W-1:0]              req_idx,
    input  logic [1:0]                    req_size,
    input  logic [NUM_CPUS*NUM_LINES-1:0] mask_flat,
    input  logic [NUM_CPUS*NUM_LINES-1:0] dir_flat,
    input  logic [NUM_LINES-1:0]          raw_q,
    output logic [NUM_CPUS-1:0]           mask_we,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic                          rsp_rvalid,
    output logic                          rsp_err
);

    localparam logic [IDX_W-1:0] DIR_BASE = IDX_W'(NUM_CPUS);
    localparam logic [IDX_W-1:0] RAW_IDX  = IDX_W'(2 * NUM_CPUS);

    rsp_state_e           state_q, state_nxt;
    logic [DATA_W-1:0]    rd_q, rd_word;
    logic                 size_ok, is_mask, is_ro, legal_rd, legal_wr;

    assign size_ok  = (req_size == FULL_WORD_SIZE);
    assign is_mask  = (req_idx < DIR_BASE);
    assign is_ro    = (req_idx >= DIR_BASE) && (req_idx <= RAW_IDX);
    assign legal_wr = req_valid && req_write && size_ok && is_mask;
    assign legal_rd = req_valid && !req_write && size_ok && (is_mask || is_ro);

    for (genvar n = 0; n < NUM_CPUS; n++) begin : g_we
        assign mask_we[n] = legal_wr && (req_idx == IDX_W'(n));
    end

    always_comb begin
        rd_word = '0;
        for (int n = 0; n < NUM_CPUS; n++) begin
            if (req_idx == IDX_W'(n))
                rd_word = DATA_W'(mask_flat[n*NUM_LINES +: NUM_LINES]);
            if (req_idx == DIR_BASE + IDX_W'(n))
                rd_word = DATA_W'(dir_flat[n*NUM_LINES +: NUM_LINES]);
        end
        if (req_idx == RAW_IDX)
            rd_word = DATA_W'(raw_q);
    end

    always_comb begin
        if (!req_valid)
            state_nxt = RSP_IDLE;
        else if (legal_rd)
            state_nxt = RSP_READ;
        else if (legal_wr)
            state_nxt = RSP_IDLE;
        else
            state_nxt = RSP_FAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_nxt;
            rd_q    <= legal_rd ? rd_word : '0;
        end
    end

    always_comb begin
        rsp_rdata  = rd_q;
        rsp_rvalid = 1'b0;
        rsp_err    = 1'b0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_READ:  rsp_rvalid = 1'b1;
            RSP_FAULT: rsp_err    = 1'b1;
            default:   rsp_err    = 1'b1;
        endcase
    end

    p_bad_size_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != FULL_WORD_SIZE) |=> (rsp_err && !rsp_rvalid));

    p_ro_write_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !is_mask) |=> rsp_err);

    p_raw_read_responds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && size_ok && req_idx == RAW_IDX)
            |=> (rsp_rvalid && rsp_rdata == DATA_W'($past(raw_q))));

    p_fault_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !size_ok) |-> (mask_we == '0));

endmodule

// File: rtl/irqr_raw.sv
module irqr_raw #(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned LINE_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic                 evt_assert,
    input  logic [LINE_W-1:0]    evt_line,
    output logic [NUM_LINES-1:0] raw_q,
    output logic [NUM_LINES-1:0] raw_nxt
);

    logic                 line_ok;
    logic [NUM_LINES-1:0] line_bit;

    assign line_ok  = (32'(evt_line) < NUM_LINES);
    assign line_bit = line_ok ? (NUM_LINES'(1) << evt_line) : '0;

    always_comb begin
        raw_nxt = raw_q;
        if (evt_valid) begin
            if (evt_assert)
                raw_nxt = raw_q | line_bit;
            else
                raw_nxt = raw_q & ~line_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_nxt;
    end

    p_assert_sets_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_assert && line_ok) |=> raw_q[$past(evt_line)]);

    p_idle_deassert_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_assert && line_ok && !raw_q[evt_line]) |=> $stable(raw_q));

    p_no_event_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> $stable(raw_q));

endmodule

// File: rtl/irqr_cpu_slice.sv
module irqr_cpu_slice #(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    input  logic [NUM_LINES-1:0] raw_q,
    input  logic [NUM_LINES-1:0] raw_nxt,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] post_q,
    output logic [NUM_LINES-1:0] wd_q,
    output logic                 irq
);

    logic [NUM_LINES-1:0] mask_nxt, dir_nxt;

    assign mask_nxt = mask_we ? mask_wdata : mask_q;
    assign dir_nxt  = mask_nxt & raw_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            dir_q  <= '0;
            post_q <= '0;
            wd_q   <= '0;
        end else begin
            mask_q <= mask_nxt;
            dir_q  <= dir_nxt;
            post_q <= dir_nxt & ~dir_q;
            wd_q   <= dir_q & ~dir_nxt;
        end
    end

    assign irq = |dir_q;

    p_routed_is_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_q == (mask_q & raw_q));

    p_post_is_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((post_q & ~dir_q) == '0) && ((post_q & $past(dir_q)) == '0));

    p_withdraw_is_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wd_q & dir_q) == '0) && ((wd_q & ~$past(dir_q)) == '0));

    p_irq_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (post_q != '0) |-> irq);

endmodule

// File: rtl/irqr_router.sv
module irqr_router
    import irqr_pkg::*;
#(
    parameter int unsigned NUM_CPUS  = 4,
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 64,
    localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int unsigned IDX_W    = ADDR_W - IDX_SHIFT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [1:0]                    req_size,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic                          rsp_rvalid,
    output logic                          rsp_err,
    input  logic                          dev_evt_valid,
    input  logic                          dev_evt_assert,
    input  logic [LINE_W-1:0]             dev_evt_line,
    output logic [NUM_CPUS-1:0]           cpu_irq,
    output logic [NUM_CPUS*NUM_LINES-1:0] cpu_post,
    output logic [NUM_CPUS*NUM_LINES-1:0] cpu_withdraw
);

    logic [NUM_LINES-1:0]          raw_q, raw_nxt;
    logic [NUM_CPUS-1:0]           mask_we;
    logic [NUM_CPUS*NUM_LINES-1:0] mask_flat, dir_flat;

    irqr_raw #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (dev_evt_valid),
        .evt_assert (dev_evt_assert),
        .evt_line   (dev_evt_line),
        .raw_q      (raw_q),
        .raw_nxt    (raw_nxt)
    );

    irqr_regif #(
        .NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES),
        .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_idx    (req_addr[ADDR_W-1:IDX_SHIFT]),
        .req_size   (req_size),
        .mask_flat  (mask_flat),
        .dir_flat   (dir_flat),
        .raw_q      (raw_q),
        .mask_we    (mask_we),
        .rsp_rdata  (rsp_rdata),
        .rsp_rvalid (rsp_rvalid),
        .rsp_err    (rsp_err)
    );

    for (genvar n = 0; n < NUM_CPUS; n++) begin : g_cpu
        irqr_cpu_slice #(.NUM_LINES(NUM_LINES)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (mask_we[n]),
            .mask_wdata (req_wdata[NUM_LINES-1:0]),
            .raw_q      (raw_q),
            .raw_nxt    (raw_nxt),
            .mask_q     (mask_flat[n*NUM_LINES +: NUM_LINES]),
            .dir_q      (dir_flat[n*NUM_LINES +: NUM_LINES]),
            .post_q     (cpu_post[n*NUM_LINES +: NUM_LINES]),
            .wd_q       (cpu_withdraw[n*NUM_LINES +: NUM_LINES]),
            .irq        (cpu_irq[n])
        );
    end

    p_retracted_line_not_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_evt_valid && !dev_evt_assert && !req_valid) |=>
            ((cpu_post & {NUM_CPUS{NUM_LINES'(1) << $past(dev_evt_line)}}) == '0));

    p_single_response_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_err && !rsp_rvalid));

endmodule

// File: tb/irqr_router_tb_top.sv
module irqr_router_tb_top;

    localparam int NC = 4;
    localparam int NL = 64;
    localparam int AW = 12;
    localparam int DW = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = 2'd3;
    logic [DW-1:0]   req_wdata = '0;
    logic [DW-1:0]   rsp_rdata;
    logic            rsp_rvalid, rsp_err;
    logic            dev_evt_valid = 1'b0, dev_evt_assert = 1'b0;
    logic [5:0]      dev_evt_line = '0;
    logic [NC-1:0]   cpu_irq;
    logic [NC*NL-1:0] cpu_post, cpu_withdraw;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NL-1:0] m_mask [NC];
    logic [NL-1:0] m_raw;

    always #4 clk = ~clk;

    irqr_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_err(rsp_err),
        .dev_evt_valid(dev_evt_valid), .dev_evt_assert(dev_evt_assert),
        .dev_evt_line(dev_evt_line),
        .cpu_irq(cpu_irq), .cpu_post(cpu_post), .cpu_withdraw(cpu_withdraw)
    );

    task automatic chk(string req, logic [NC*NL-1:0] act, logic [NC*NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_read(int idx);
        if (idx < NC) return m_mask[idx];
        if (idx < 2*NC) return m_mask[idx-NC] & m_raw;
        return m_raw;
    endfunction

    // One accepted cycle: drive, predict, wait one edge, compare at negedge.
    task automatic cycle(bit rv, bit wr, int idx, int low, logic [1:0] sz,
                         logic [DW-1:0] wd, bit ev, bit ea, int line, string rd_tag);
        logic [NL-1:0] old_dir [NC];
        logic [NL-1:0] new_mask [NC];
        logic [NL-1:0] new_raw;
        logic [NC*NL-1:0] e_post, e_wd;
        logic [NC-1:0] e_irq;
        bit lw, lr, e_err;
        logic [DW-1:0] e_rd;
        req_valid = rv; req_write = wr;
        req_addr = AW'((idx << 6) | low); req_size = sz; req_wdata = wd;
        dev_evt_valid = ev; dev_evt_assert = ea; dev_evt_line = 6'(line);
        lw = rv && wr && sz == 2'd3 && idx < NC;
        lr = rv && !wr && sz == 2'd3 && idx <= 2*NC;
        e_err = rv && !lw && !lr;
        e_rd = lr ? model_read(idx) : '0;
        new_raw = m_raw;
        if (ev) new_raw = ea ? (m_raw | (NL'(1) << line)) : (m_raw & ~(NL'(1) << line));
        for (int n = 0; n < NC; n++) begin
            old_dir[n] = m_mask[n] & m_raw;
            new_mask[n] = (lw && idx == n) ? wd : m_mask[n];
            e_post[n*NL +: NL] = (new_mask[n] & new_raw) & ~old_dir[n];
            e_wd[n*NL +: NL] = old_dir[n] & ~(new_mask[n] & new_raw);
            e_irq[n] = |(new_mask[n] & new_raw);
        end
        for (int n = 0; n < NC; n++) m_mask[n] = new_mask[n];
        m_raw = new_raw;
        @(negedge clk);
        chk("R7", NC*NL'(cpu_irq), NC*NL'(e_irq));
        chk(lw ? "R3" : "R5", cpu_post, e_post);
        chk(lw ? "R4" : "R6", cpu_withdraw, e_wd);
        chk(sz != 2'd3 ? "R9" : "R8", NC*NL'(rsp_err), NC*NL'(e_err));
        chk("R2", NC*NL'(rsp_rvalid), NC*NL'(lr));
        if (lr) chk(rd_tag, NC*NL'(rsp_rdata), NC*NL'(e_rd));
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 2'd3, '0, 0, 0, 0, "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < NC; n++) m_mask[n] = '0;
        m_raw = '0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", NC*NL'(cpu_irq), '0);
        chk("R1", cpu_post | cpu_withdraw, '0);
        chk("R1", NC*NL'({rsp_err, rsp_rvalid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        cycle(1, 0, 8, 0, 2'd3, '0, 0, 0, 0, "R1");
        cycle(1, 0, 4, 0, 2'd3, '0, 0, 0, 0, "R1");
        // R5: pending with no mask set
        cycle(0, 0, 0, 0, 2'd3, '0, 1, 1, 5, "R5");
        // R3: mask write reveals pending line 5
        cycle(1, 1, 0, 0, 2'd3, 64'h220, 0, 0, 0, "R3");
        // R11: read right after write sees the new mask
        cycle(1, 0, 0, 0, 2'd3, '0, 0, 0, 0, "R11");
        cycle(0, 0, 0, 0, 2'd3, '0, 1, 1, 9, "R5");
        // R5: repeated assertion is silent
        cycle(0, 0, 0, 0, 2'd3, '0, 1, 1, 9, "R5");
        // R4: dropping bit 5 from the mask
        cycle(1, 1, 0, 0, 2'd3, 64'h200, 0, 0, 0, "R4");
        // R6: idle deassert ignored, then raw read shows it unchanged
        cycle(0, 0, 0, 0, 2'd3, '0, 1, 0, 20, "R6");
        cycle(1, 0, 8, 0, 2'd3, '0, 0, 0, 0, "R6");
        cycle(0, 0, 0, 0, 2'd3, '0, 1, 0, 9, "R6");
        // R8: writes to read-only and unmapped indices
        cycle(1, 1, 4, 0, 2'd3, '1, 0, 0, 0, "R8");
        cycle(1, 1, 8, 0, 2'd3, '1, 0, 0, 0, "R8");
        cycle(1, 0, 9, 0, 2'd3, '0, 0, 0, 0, "R8");
        // R9: narrow accesses
        cycle(1, 1, 1, 0, 2'd2, '1, 0, 0, 0, "R9");
        cycle(1, 0, 0, 0, 2'd0, '0, 0, 0, 0, "R9");
        cycle(1, 0, 1, 0, 2'd3, '0, 0, 0, 0, "R9");
        // R10: low offset bits ignored
        cycle(1, 0, 0, 6'h38, 2'd3, '0, 0, 0, 0, "R10");
        cycle(1, 1, 2, 6'h07, 2'd3, 64'hF0, 0, 0, 0, "R10");
        cycle(1, 0, 2, 0, 2'd3, '0, 0, 0, 0, "R10");
        idle();
        // Random mix with a fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 1500; i++) begin
            int op = $urandom % 10;
            int ln = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 8);
            logic [DW-1:0] w = {$urandom, $urandom};
            if ($urandom % 2 == 0) w = w & 64'hFF;
            case (op)
                0, 1, 2: cycle(0, 0, 0, 0, 2'd3, '0, 1, $urandom % 2, ln, "R2");
                3, 4:    cycle(1, 1, $urandom % NC, $urandom % 64, 2'd3, w,
                               $urandom % 3 == 0, $urandom % 2, ln, "R2");
                5, 6, 7: cycle(1, 0, $urandom % (2*NC+1), $urandom % 64, 2'd3, '0,
                               $urandom % 2, $urandom % 2, ln, "R2");
                8:       cycle(1, $urandom % 2, $urandom % 64, 0, 2'($urandom % 3), w,
                               0, 0, 0, "R9");
                default: cycle(1, 1, NC + $urandom % 60, 0, 2'd3, w,
                               $urandom % 2, $urandom % 2, ln, "R8");
            endcase
        end
        idle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule